// File: doc/BRIEF.md
# Interrupt Entry Register-Save Sequencer

This block performs the state save that a processor needs when it enters one of two interrupt classes: a user-level class whose handler lives in the application, and a system-level class whose handler lives in the operating system. Either class may be requested by a hardware exception or by an explicit software-interrupt instruction. Instruction decode classifies the request and raises the matching request line.

On the clock edge that accepts an entry, the block does several things. It copies the value of general register 255 into the class's bootstrap register. It writes the return-jump register value back into general register 255 through a dedicated write port. It stores the following-instruction address, the interrupted instruction word and its two operands in a save bank that belongs to the class. It loads the new program counter from the class's vector register. A done pulse follows one cycle after the program-counter load.

When both classes are requested in the same cycle, the system class is accepted first. The user class is held pending and is accepted on the next cycle. The captured values for a pending entry are the inputs present in the cycle in which that entry is accepted.

Top module: `irq_save_seq`

## Requirements
- R1: After synchronous active-low reset, every bank register, `gr255_we`, `pc_load`, `done` and the pending user request read zero.
- R2: A user-class entry (`trip_req` high, `trap_req` low) loads `boot_trip` with `gr255_in`. In the next cycle it presents `gr255_we`=1 with `gr255_wdata` equal to `rj_in`.
- R3: A system-class entry (`trap_req` high) loads `boot_trap` with `gr255_in`. In the next cycle it presents `gr255_we`=1 with `gr255_wdata` equal to `rj_in`.
- R4: The accepted class's where-register captures `pc_in + 4`, modulo 2^64.
- R5: The accepted class's exec-register captures `insn_in`.
- R6: The accepted class's operand registers capture `y_in` and `z_in`.
- R7: In the cycle after acceptance, `pc_load` is 1 and `pc_new` equals `vec_trip` for a user entry or `vec_trap` for a system entry. `entry_trap` is 1 only for a system entry.
- R8: If both requests are high in one cycle, the system entry is accepted in that cycle. The user entry is accepted in the following cycle, even though `trip_req` has gone low.
- R9: `done` is high for exactly one cycle, in the cycle after each `pc_load` cycle.
- R10: The save bank and bootstrap register of the class that is not accepted keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_req | input | 1 | User-class entry request |
| trap_req | input | 1 | System-class entry request |
| pc_in | input | 64 | Address of the interrupted instruction |
| insn_in | input | 64 | Interrupted instruction word |
| y_in | input | 64 | Y operand of the interrupted instruction |
| z_in | input | 64 | Z operand of the interrupted instruction |
| gr255_in | input | 64 | Current value of general register 255 |
| rj_in | input | 64 | Current return-jump register value |
| vec_trip | input | 64 | User-class handler vector |
| vec_trap | input | 64 | System-class handler vector |
| gr255_we | output | 1 | Write strobe for general register 255 |
| gr255_wdata | output | 64 | Data for general register 255 |
| pc_load | output | 1 | New program counter valid |
| pc_new | output | 64 | Handler address |
| entry_trap | output | 1 | Accepted entry was system class |
| done | output | 1 | Save sequence complete |
| boot_trip | output | 64 | User-class bootstrap register |
| boot_trap | output | 64 | System-class bootstrap register |
| where_trip | output | 64 | User-class resume address |
| exec_trip | output | 64 | User-class saved instruction |
| yop_trip | output | 64 | User-class saved Y operand |
| zop_trip | output | 64 | User-class saved Z operand |
| where_trap | output | 64 | System-class resume address |
| exec_trap | output | 64 | System-class saved instruction |
| yop_trap | output | 64 | System-class saved Y operand |
| zop_trap | output | 64 | System-class saved Z operand |

## Verification
The two functions that can collide are a user-class entry and a system-class entry, requested in the same cycle. The bench raises both request lines on one edge and then drops them. Between the two acceptances it changes the instruction, operand and address inputs. It then checks three things. The system bank must hold the first set of values with the system vector on `pc_new`. The user bank must hold the second set with the user vector one cycle later. The `done` pulses must trail each load by one cycle.

// File: rtl/irq_save_seq.sv
module irq_save_seq #(
  parameter int DW = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_req,
  input  logic          trap_req,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] insn_in,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] z_in,
  input  logic [DW-1:0] gr255_in,
  input  logic [DW-1:0] rj_in,
  input  logic [DW-1:0] vec_trip,
  input  logic [DW-1:0] vec_trap,
  output logic          gr255_we,
  output logic [DW-1:0] gr255_wdata,
  output logic          pc_load,
  output logic [DW-1:0] pc_new,
  output logic          entry_trap,
  output logic          done,
  output logic [DW-1:0] boot_trip,
  output logic [DW-1:0] boot_trap,
  output logic [DW-1:0] where_trip,
  output logic [DW-1:0] exec_trip,
  output logic [DW-1:0] yop_trip,
  output logic [DW-1:0] zop_trip,
  output logic [DW-1:0] where_trap,
  output logic [DW-1:0] exec_trap,
  output logic [DW-1:0] yop_trap,
  output logic [DW-1:0] zop_trap
);

  localparam logic [DW-1:0] STEP = DW'(INSN_BYTES);

  logic          trip_pend;
  logic          take_trap, take_trip, take_any, trip_want;
  logic [DW-1:0] bk_boot  [2];
  logic [DW-1:0] bk_where [2];
  logic [DW-1:0] bk_exec  [2];
  logic [DW-1:0] bk_y     [2];
  logic [DW-1:0] bk_z     [2];

  assign trip_want = trip_req | trip_pend;
  assign take_trap = trap_req;
  assign take_trip = trip_want & ~trap_req;
  assign take_any  = take_trap | take_trip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_pend   <= 1'b0;
      gr255_we    <= 1'b0;
      gr255_wdata <= '0;
      pc_load     <= 1'b0;
      pc_new      <= '0;
      entry_trap  <= 1'b0;
      done        <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        bk_boot[i]  <= '0;
        bk_where[i] <= '0;
        bk_exec[i]  <= '0;
        bk_y[i]     <= '0;
        bk_z[i]     <= '0;
      end
    end else begin
      trip_pend  <= trip_want & ~take_trip;
      gr255_we   <= take_any;
      pc_load    <= take_any;
      entry_trap <= take_trap;
      done       <= pc_load;
      if (take_any) begin
        gr255_wdata                  <= rj_in;
        pc_new                       <= take_trap ? vec_trap : vec_trip;
        bk_boot[int'(take_trap)]  <= gr255_in;
        bk_where[int'(take_trap)] <= pc_in + STEP;
        bk_exec[int'(take_trap)]  <= insn_in;
        bk_y[int'(take_trap)]     <= y_in;
        bk_z[int'(take_trap)]     <= z_in;
      end
    end
  end

  assign boot_trip  = bk_boot[0];
  assign boot_trap  = bk_boot[1];
  assign where_trip = bk_where[0];
  assign where_trap = bk_where[1];
  assign exec_trip  = bk_exec[0];
  assign exec_trap  = bk_exec[1];
  assign yop_trip   = bk_y[0];
  assign yop_trap   = bk_y[1];
  assign zop_trip   = bk_z[0];
  assign zop_trap   = bk_z[1];

  a_r9_done_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pc_load));
  a_r2_gr255_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    gr255_we == pc_load);
  a_r7_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (pc_load && entry_trap && pc_new == $past(vec_trap)));
  a_r8_trip_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trip_req) |=> trip_pend);
  a_r10_trap_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> ($stable(where_trap) && $stable(boot_trap)));
  a_r10_trip_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_want |=> ($stable(where_trip) && $stable(boot_trip)));

endmodule

// File: tb/tb_irq_save_seq.sv
module tb_irq_save_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_req = 1'b0, trap_req = 1'b0;
  logic [63:0] pc_in = '0, insn_in = '0, y_in = '0, z_in = '0;
  logic [63:0] gr255_in = '0, rj_in = '0, vec_trip = '0, vec_trap = '0;
  logic gr255_we, pc_load, entry_trap, done;
  logic [63:0] gr255_wdata, pc_new;
  logic [63:0] boot_trip, boot_trap, where_trip, exec_trip, yop_trip, zop_trip;
  logic [63:0] where_trap, exec_trap, yop_trap, zop_trap;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  irq_save_seq dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctx(input logic [63:0] base);
    pc_in = base; insn_in = base ^ 64'h1111; y_in = base + 64'd7; z_in = base + 64'd9;
    gr255_in = base ^ 64'hFF00; rj_in = base ^ 64'h00AA;
  endtask

  task automatic t_reset;
    chk("R1 boot_trip", boot_trip, 0);  chk("R1 boot_trap", boot_trap, 0);
    chk("R1 where_trip", where_trip, 0); chk("R1 zop_trap", zop_trap, 0);
    chk("R1 gr255_we", {63'd0, gr255_we}, 0);
    chk("R1 pc_load", {63'd0, pc_load}, 0); chk("R1 done", {63'd0, done}, 0);
  endtask

  task automatic t_trip(input logic [63:0] base);
    logic [63:0] tb_where = where_trap;
    @(negedge clk); set_ctx(base); trip_req = 1'b1;
    @(negedge clk); trip_req = 1'b0;
    chk("R2 boot_trip", boot_trip, base ^ 64'hFF00);
    chk("R2 gr255_we", {63'd0, gr255_we}, 1);
    chk("R2 gr255_wdata", gr255_wdata, base ^ 64'h00AA);
    chk("R4 where_trip", where_trip, base + 64'd4);
    chk("R5 exec_trip", exec_trip, base ^ 64'h1111);
    chk("R6 yop_trip", yop_trip, base + 64'd7);
    chk("R6 zop_trip", zop_trip, base + 64'd9);
    chk("R7 pc_load", {63'd0, pc_load}, 1);
    chk("R7 pc_new trip", pc_new, vec_trip);
    chk("R7 entry_trap", {63'd0, entry_trap}, 0);
    chk("R10 trap bank kept", where_trap, tb_where);
    @(negedge clk);
    chk("R9 done", {63'd0, done}, 1);
    chk("R9 pc_load low", {63'd0, pc_load}, 0);
    @(negedge clk);
    chk("R9 done one cycle", {63'd0, done}, 0);
  endtask

  task automatic t_trap(input logic [63:0] base);
    logic [63:0] tr_boot = boot_trip;
    @(negedge clk); set_ctx(base); trap_req = 1'b1;
    @(negedge clk); trap_req = 1'b0;
    chk("R3 boot_trap", boot_trap, base ^ 64'hFF00);
    chk("R3 gr255_wdata", gr255_wdata, base ^ 64'h00AA);
    chk("R4 where_trap", where_trap, base + 64'd4);
    chk("R5 exec_trap", exec_trap, base ^ 64'h1111);
    chk("R6 yop_trap", yop_trap, base + 64'd7);
    chk("R6 zop_trap", zop_trap, base + 64'd9);
    chk("R7 pc_new trap", pc_new, vec_trap);
    chk("R7 entry_trap", {63'd0, entry_trap}, 1);
    chk("R10 trip bank kept", boot_trip, tr_boot);
    @(negedge clk);
    chk("R9 done trap", {63'd0, done}, 1);
  endtask

  task automatic t_both;
    @(negedge clk); set_ctx(64'hA000); trip_req = 1'b1; trap_req = 1'b1;
    @(negedge clk); trip_req = 1'b0; trap_req = 1'b0;
    chk("R8 trap first where", where_trap, 64'hA004);
    chk("R8 trap first pc_new", pc_new, vec_trap);
    chk("R8 entry_trap", {63'd0, entry_trap}, 1);
    set_ctx(64'hB000);
    @(negedge clk);
    chk("R8 trip next pc_load", {63'd0, pc_load}, 1);
    chk("R8 trip next pc_new", pc_new, vec_trip);
    chk("R8 trip bank", where_trip, 64'hB004);
    chk("R8 trip boot", boot_trip, 64'hB000 ^ 64'hFF00);
    chk("R9 done after trap", {63'd0, done}, 1);
    chk("R10 trap bank kept", where_trap, 64'hA004);
    @(negedge clk);
    chk("R9 done after trip", {63'd0, done}, 1);
    chk("R8 no third load", {63'd0, pc_load}, 0);
    @(negedge clk);
    chk("R9 done clear", {63'd0, done}, 0);
  endtask

  initial begin
    vec_trip = 64'h0000_0000_0000_0100;
    vec_trap = 64'h8000_0000_0000_0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_trip(64'h1000);
    t_trap(64'h2000);
    t_trip(64'hFFFF_FFFF_FFFF_FFFE);
    t_both();
    t_trap(64'h3000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule